// File: doc/BRIEF.md
# Power-Fail Write Protect Controller

This block sits between a host bus and a byte-wide static memory. It watches the host's active-low chip enable, output enable and write enable, and turns them into two memory-side controls: a one-cycle write strobe that fires when a host write finishes, and an enable for the output drivers during reads. All control inputs are sampled on the block clock.

A power-fail indication from an external comparator passes through a two-flop synchronizer. While it is asserted the memory is fully deselected: outputs are off, control inputs are ignored and a write in flight is aborted. Access stays closed for a recovery interval, given in clock cycles, after the indication clears. A battery-low indication is captured each time power returns. When it is captured as set, the next write to complete is swallowed without a strobe and the flag then clears itself, so a host can detect a weak battery with a write-then-read-back test. Reset is treated like a return of power.

Top module: `pwr_guard_ctrl`

## Requirements
- R1: While rst_n is low, mem_we, drive_en and batt_flag are 0. After release, access stays closed as after a power return: a read held from the release first gives drive_en = 1 after the (REC_CYCLES+3)-th rising edge.
- R2: power_fail passes through two synchronizing flops. From the third rising edge after it is first sampled at 1, mem_we and drive_en are 0, whatever ce_n, oe_n and we_n do.
- R3: After power_fail is first sampled at 0, access stays closed for REC_CYCLES cycles beyond the synchronizer delay. A read held throughout first gives drive_en = 1 after the (REC_CYCLES+3)-th rising edge, counting the edge that sampled power_fail at 0.
- R4: batt_flag loads the value of batt_low once per power return, on the edge after the synchronized power-fail falls. It changes at no other time except as in R6.
- R5: While batt_flag is 1, the first write to complete with access open produces no mem_we pulse.
- R6: That swallowed write clears batt_flag to 0. Later writes produce strobes again.
- R7: mem_we is high for exactly one cycle for each completed write.
- R8: A write is active while ce_n and we_n are both 0. mem_we is 1 in the cycle after the first rising edge at which either input is sampled at 1, provided the previous edge sampled both at 0.
- R9: drive_en is 1 in the cycle after an edge that sampled ce_n = 0, oe_n = 0 and we_n = 1 with access open. At any other time it is 0, so pulling we_n low turns the outputs off.
- R10: A write that is active when access closes is aborted. It gives no mem_we pulse even if it ends later, and it does not clear batt_flag.
- R11: A write that starts and ends while access is closed has no effect: no pulse, and batt_flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| power_fail | input | 1 | Asynchronous supply-out-of-range indication, active high |
| batt_low | input | 1 | Battery-low indication, captured at power return |
| mem_we | output | 1 | One-cycle write strobe to the memory array |
| drive_en | output | 1 | Enable for the data output drivers |
| batt_flag | output | 1 | Sticky battery-not-OK status |

## Verification
Each result has a fixed latency. drive_en follows a sampled read request after one rising edge. The write strobe is due one edge after the write-end edge. power_fail gates the outputs from the third edge. A reopening read is due after REC_CYCLES+3 edges, and the captured battery flag is visible one edge after the synchronized power-fail falls. The bench drives inputs and samples outputs only on falling edges. A cycle model advanced on each rising edge predicts every output at the next falling edge, and the directed tests count edges to the exact opening and closing points.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef struct packed {
        logic wr_busy;
        logic strobe;
        logic drive;
        logic flag;
    } acc_state_t;

    function automatic logic wr_req(input logic ce_n, input logic we_n);
        return !ce_n && !we_n;
    endfunction

    function automatic logic rd_req(input logic ce_n, input logic oe_n, input logic we_n);
        return !ce_n && !oe_n && we_n;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_d[i] = d;
        end else begin : g_next
            assign stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pg_recovery.sv
module pg_recovery #(
    parameter int REC_CYCLES = 100000,
    parameter int REC_W      = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_sync,
    output logic blocked,
    output logic rise
);
    typedef struct packed {
        logic [REC_W-1:0] cnt;
        logic             last;
    } rec_t;

    rec_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.last = pf_sync;
        if (pf_sync)
            nxt_d.cnt = REC_W'(REC_CYCLES);
        else if (cur_q.cnt != '0)
            nxt_d.cnt = cur_q.cnt - REC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt  <= '0;
            cur_q.last <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign blocked = pf_sync || (cur_q.cnt != '0);
    assign rise    = cur_q.last && !pf_sync;
endmodule

// File: rtl/pg_access.sv
module pg_access
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic blocked,
    input  logic rise,
    input  logic batt_low,
    output logic mem_we,
    output logic drive_en,
    output logic batt_flag
);
    acc_state_t st_q, st_d;
    logic wr_now;

    always_comb begin
        wr_now    = wr_req(ce_n, we_n);
        st_d      = st_q;
        st_d.strobe = 1'b0;
        if (blocked) begin
            st_d.wr_busy = 1'b0;
            st_d.drive   = 1'b0;
            if (rise) st_d.flag = batt_low;
        end else begin
            st_d.wr_busy = wr_now;
            st_d.drive   = rd_req(ce_n, oe_n, we_n);
            if (st_q.wr_busy && !wr_now) begin
                if (st_q.flag) st_d.flag   = 1'b0;
                else           st_d.strobe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = st_q.strobe;
    assign drive_en  = st_q.drive;
    assign batt_flag = st_q.flag;
endmodule

// File: rtl/pwr_guard_ctrl.sv
module pwr_guard_ctrl #(
    parameter int REC_CYCLES  = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic power_fail,
    input  logic batt_low,
    output logic mem_we,
    output logic drive_en,
    output logic batt_flag
);
    localparam int REC_W = $clog2(REC_CYCLES + 1);

    logic pf_sync;
    logic blocked;
    logic rise;

    pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (power_fail),
        .q     (pf_sync)
    );

    pg_recovery #(.REC_CYCLES(REC_CYCLES), .REC_W(REC_W)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pf_sync (pf_sync),
        .blocked (blocked),
        .rise    (rise)
    );

    pg_access u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .blocked   (blocked),
        .rise      (rise),
        .batt_low  (batt_low),
        .mem_we    (mem_we),
        .drive_en  (drive_en),
        .batt_flag (batt_flag)
    );
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
    parameter int REC_CYCLES = 100000
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic power_fail,
    input logic batt_low,
    input logic mem_we,
    input logic drive_en,
    input logic batt_flag
);
    localparam int CW = $clog2(REC_CYCLES + 4) + 1;

    // cycles since power_fail was last sampled high
    logic [CW-1:0] quiet_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                quiet_q <= '0;
        else if (power_fail)       quiet_q <= '0;
        else if (quiet_q != '1)    quiet_q <= quiet_q + CW'(1);
    end

    p_pf_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(power_fail, 3) |-> (!mem_we && !drive_en));

    p_recovery_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((quiet_q >= CW'(2)) && (quiet_q <= CW'(REC_CYCLES + 2))) |-> (!mem_we && !drive_en));

    p_flag_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_flag) |-> $past(batt_low));

    p_no_strobe_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(batt_flag));

    p_flag_clear_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(batt_flag) |-> !mem_we);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_strobe_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (($past(ce_n) || $past(we_n)) && !$past(ce_n, 2) && !$past(we_n, 2)));

    p_drive_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $past(!ce_n && !oe_n && we_n));
endmodule

bind pwr_guard_ctrl pwr_guard_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (.*);

// File: tb/sim_pwr_guard_ctrl.sv
module sim_pwr_guard_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int REC        = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic power_fail = 1'b0, batt_low = 1'b1;
    logic mem_we, drive_en, batt_flag;

    int tests = 0, fails = 0, pulses = 0;
    bit model_on = 1'b0, done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_guard_ctrl #(.REC_CYCLES(REC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .power_fail(power_fail), .batt_low(batt_low),
        .mem_we(mem_we), .drive_en(drive_en), .batt_flag(batt_flag)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // cycle model built from the requirements
    logic m_s1, m_s2, m_prev, m_wr, m_we, m_drv, m_flag;
    int   m_rec;
    always @(posedge clk or negedge rst_n) begin : mdl
        logic blk, wq;
        if (!rst_n) begin
            m_s1 <= 1; m_s2 <= 1; m_prev <= 1; m_rec <= 0;
            m_wr <= 0; m_we <= 0; m_drv <= 0; m_flag <= 0;
        end else begin
            blk = m_s2 || (m_rec != 0);
            wq  = !ce_n && !we_n;
            m_s1 <= power_fail; m_s2 <= m_s1; m_prev <= m_s2;
            m_rec <= m_s2 ? REC : (m_rec > 0 ? m_rec - 1 : 0);
            m_we <= 1'b0;
            if (blk) begin
                m_wr <= 0; m_drv <= 0;
                if (m_prev && !m_s2) m_flag <= batt_low;
            end else begin
                m_wr  <= wq;
                m_drv <= !ce_n && !oe_n && we_n;
                if (m_wr && !wq) begin
                    if (m_flag) m_flag <= 1'b0;
                    else        m_we   <= 1'b1;
                end
            end
        end
    end

    function automatic int bi(input logic v);
        return (v === 1'b1) ? 1 : 0;
    endfunction

    always @(negedge clk) begin
        if (mem_we === 1'b1) pulses++;
        if (rst_n && model_on) begin
            chk("R8", "mem_we vs model", bi(mem_we), bi(m_we));
            chk("R9", "drive_en vs model", bi(drive_en), bi(m_drv));
            chk("R4", "batt_flag vs model", bi(batt_flag), bi(m_flag));
        end
    end

    task automatic idle();
        ce_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic hold_read();
        ce_n = 0; oe_n = 0; we_n = 1;
    endtask

    // called at a falling edge; counts rising edges until drive_en opens
    task automatic edges_to_open(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (drive_en !== 1'b1 && n < REC + 40);
    endtask

    task automatic edges_to_close(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (drive_en !== 1'b0 && n < 20);
    endtask

    // write lasting h cycles; reports mem_we at the two falling edges after the end
    task automatic write_op(input int h, output int first, output int second);
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0;
        repeat (h) @(negedge clk);
        we_n = 1;
        @(negedge clk); first = bi(mem_we); ce_n = 1;
        @(negedge clk); second = bi(mem_we);
    endtask

    initial begin
        int n, a, b, p0, seed_v;
        seed_v = $urandom(32'h5EED_0042);
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "mem_we in reset", bi(mem_we), 0);
        chk("R1", "drive_en in reset", bi(drive_en), 0);
        chk("R1", "batt_flag in reset", bi(batt_flag), 0);
        hold_read();
        rst_n = 1; model_on = 1;
        edges_to_open(n);
        chk("R1", "edges from reset release to open", n, REC + 3);
        chk("R4", "flag captured after reset", bi(batt_flag), 1);
        idle();

        // R5 swallowed write, R6 clear then normal
        p0 = pulses;
        write_op(2, a, b);
        chk("R5", "no strobe while flagged", pulses - p0, 0);
        chk("R6", "flag cleared by write", bi(batt_flag), 0);
        p0 = pulses;
        write_op(3, a, b);
        chk("R8", "strobe one edge after write end", a, 1);
        chk("R7", "strobe gone next cycle", b, 0);
        chk("R6", "one strobe after clear", pulses - p0, 1);

        // R9 read drive and we_n override
        @(negedge clk); hold_read();
        @(negedge clk); chk("R9", "drive on read", bi(drive_en), 1);
        we_n = 0;
        @(negedge clk); chk("R9", "we_n low turns drive off", bi(drive_en), 0);
        we_n = 1;
        @(negedge clk); chk("R9", "drive back on", bi(drive_en), 1);

        // R2 closing latency, R11 writes while closed
        batt_low = 1; power_fail = 1;
        edges_to_close(n);
        chk("R2", "edges from power_fail to close", n, 3);
        idle();
        p0 = pulses;
        write_op(2, a, b);
        chk("R11", "no strobe during power fail", pulses - p0, 0);
        @(negedge clk); hold_read(); power_fail = 0;
        edges_to_open(n);
        chk("R3", "edges from power return to open", n, REC + 3);
        chk("R4", "flag recaptured high", bi(batt_flag), 1);
        idle();

        // R11 write inside recovery keeps flag
        @(negedge clk); power_fail = 1;
        repeat (4) @(negedge clk); power_fail = 0;
        repeat (4) @(negedge clk);
        p0 = pulses;
        write_op(2, a, b);
        repeat (REC) @(negedge clk);
        chk("R11", "no strobe in recovery", pulses - p0, 0);
        chk("R11", "flag kept after ignored write", bi(batt_flag), 1);
        write_op(1, a, b);
        chk("R5", "swallowed first open write", pulses - p0, 0);
        chk("R6", "flag cleared", bi(batt_flag), 0);

        // R10 abort of a write in flight, flag stays low with batt_low 0
        batt_low = 0;
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1;
        repeat (2) @(negedge clk);
        p0 = pulses; power_fail = 1;
        repeat (5) @(negedge clk); idle();
        @(negedge clk); power_fail = 0;
        repeat (REC + 6) @(negedge clk);
        chk("R10", "aborted write gives no strobe", pulses - p0, 0);
        chk("R4", "flag captured low", bi(batt_flag), 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (power_fail) power_fail = ($urandom % 100) < 80;
            else            power_fail = ($urandom % 1000) < 8;
            if (($urandom % 50) == 0) batt_low = $urandom % 2;
            if (($urandom % 3) == 0) ce_n = ($urandom % 4) == 0;
            if (($urandom % 3) == 0) oe_n = $urandom % 2;
            if (($urandom % 3) == 0) we_n = ($urandom % 3) != 0;
        end
        idle(); power_fail = 0;
        repeat (REC + 6) @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule